// File: doc/BRIEF.md
# Watchdog Timer with Guarded Shutdown

This block is a watchdog counter for a processor subsystem. Once enabled, it counts ticks of a slow time base, offered here as a one-cycle `tick_en` strobe in the system clock domain. If software fails to pulse `kick` before the selected period runs out, the block raises `sys_rst_req` for one clock. After that pulse the count starts again from zero. The period is picked from eight power-of-two lengths. The shortest period is set by the parameter `BASE_SHIFT`, which is 14 by default and may be made small for simulation.

Software controls the block through a single 8-bit control register on a plain write-strobe bus, and it reads the register back on `bus_rdata`. Turning the watchdog on is always allowed. Turning it off takes two steps. The first write sets the shutdown-unlock bit and the enable bit together. This opens a four-cycle window, which the hardware later closes by itself. An enable-clear write only takes effect inside that window.

A three-state machine tracks the enable bit and the window. **ST_OFF** means disabled. **ST_ARMED** means enabled with the window closed. **ST_UNLOCKED** means enabled with the window open. The transitions are:
- *arm* (ST_OFF to ST_ARMED): a write sets enable while the window will be closed after the write.
- *arm_open* (ST_OFF to ST_UNLOCKED): a write sets enable while the window is open after the write.
- *unlock* (ST_ARMED to ST_UNLOCKED): a write sets the unlock bit.
- *shutdown* (ST_UNLOCKED to ST_OFF): a write clears enable.
- *relock* (ST_UNLOCKED to ST_ARMED): the window lapses with no shutdown write.

Top module: `wdog_guard`

## Requirements
- R1: After reset, `bus_rdata` reads 0x00 and `sys_rst_req` is low. The watchdog is disabled.
- R2: Bits 7:5 of `bus_rdata` always read zero, whatever was written to them.
- R3: A write with bit 3 (enable) set enables the watchdog in any state.
- R4: A write with bit 4 (unlock) set makes bit 4 read one in the four cycles after that write. Bit 4 then clears by itself in the fifth cycle.
- R5: A write with bit 3 clear while bit 4 reads zero leaves the enable bit at one. The same write still loads bits 2:0 (period select).
- R6: A write of bit 3 = 0 disables the watchdog when it lands 1 to 4 cycles after a write that set bits 4 and 3 together. The same write landing 5 cycles after is refused.
- R7: While enabled, 2^(BASE_SHIFT+n) counted ticks with no kick, where n is the value of bits 2:0, give a one-cycle `sys_rst_req` pulse. The count then restarts from zero.
- R8: A `kick` clears the count. When `kick` and `tick_en` fall in the same cycle, the kick wins and that tick is not counted.
- R9: While disabled, the count is held at zero and no reset pulse is issued. After re-enabling, a full period is needed.
- R10: A write that changes bits 2:0 clears the count. A write that keeps the same period select does not.
- R11: Cycles with `tick_en` low do not advance the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Time-base strobe; each high cycle counts one tick |
| kick | input | 1 | Restart strobe that clears the count |
| bus_wr | input | 1 | Control register write strobe |
| bus_wdata | input | 8 | Control register write data |
| bus_rdata | output | 8 | Control register read data: {000, unlock, enable, select[2:0]} |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The counting path is exercised with several tick patterns. One is a long unbroken tick run that yields back-to-back timeouts, which shows that the count restarts after expiry. Another is a tick run split by idle gaps, which shows that only strobed cycles count. Others are a kick in mid-count, and a kick in the same cycle as a tick, which separates kick priority from plain clearing. Period-select writes are tried with both a changed and an unchanged value, which separates a clear-on-change from a clear-on-any-write. The shutdown write is placed one, four and five cycles after the unlock write to locate both edges of the window. Ticks applied while the watchdog is disabled, followed by a re-enable, show that the count is held rather than merely frozen.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int unsigned CTL_W    = 8;
    localparam int unsigned SEL_W    = 3;
    localparam int unsigned UNLK_BIT = 4;
    localparam int unsigned EN_BIT   = 3;
    localparam int unsigned WIN_LEN  = 4;

    typedef enum logic [1:0] {
        ST_OFF      = 2'd0,
        ST_ARMED    = 2'd1,
        ST_UNLOCKED = 2'd2
    } wd_state_e;

endpackage

// File: rtl/wdog_unlock_timer.sv
module wdog_unlock_timer #(
    parameter int unsigned WIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic open_q,
    output logic open_d
);
    localparam int unsigned AW = (WIN > 1) ? $clog2(WIN) : 1;

    logic [AW-1:0] age_q, age_d;

    always_comb begin
        open_d = open_q;
        age_d  = age_q;
        if (arm) begin
            open_d = 1'b1;
            age_d  = '0;
        end else if (open_q) begin
            if (age_q == AW'(WIN - 1)) begin
                open_d = 1'b0;
            end else begin
                age_d = age_q + AW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            age_q  <= '0;
        end else begin
            open_q <= open_d;
            age_q  <= age_d;
        end
    end

endmodule

// File: rtl/wdog_tick_counter.sv
module wdog_tick_counter #(
    parameter int unsigned BASE_SHIFT = 14,
    parameter int unsigned SEL_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic             kick,
    input  logic             tick,
    input  logic [SEL_W-1:0] sel,
    output logic             expire
);
    localparam int unsigned CW = BASE_SHIFT + (1 << SEL_W) - 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;

    always_comb begin
        last   = (CW'(1) << (BASE_SHIFT + int'(sel))) - CW'(1);
        expire = run && tick && !kick && !clr && (cnt_q == last);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || clr || kick || expire) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
    import wdog_pkg::*;
#(
    parameter int unsigned BASE_SHIFT = 14
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       kick,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       sys_rst_req
);
    wd_state_e        state_q, state_d;
    logic [SEL_W-1:0] sel_q;
    logic             open_q, open_d;
    logic             wr_unlock, wr_enable, sel_change, run, expire;
    logic             unused_hi;

    assign unused_hi  = ^bus_wdata[CTL_W-1:UNLK_BIT+1];
    assign wr_unlock  = bus_wr && bus_wdata[UNLK_BIT];
    assign wr_enable  = bus_wdata[EN_BIT];
    assign sel_change = bus_wr && (bus_wdata[SEL_W-1:0] != sel_q);
    assign run        = (state_q != ST_OFF);

    wdog_unlock_timer #(.WIN(WIN_LEN)) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (wr_unlock),
        .open_q (open_q),
        .open_d (open_d)
    );

    wdog_tick_counter #(.BASE_SHIFT(BASE_SHIFT), .SEL_W(SEL_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .clr    (sel_change),
        .kick   (kick),
        .tick   (tick_en),
        .sel    (sel_q),
        .expire (expire)
    );

    // next-state logic: named transitions arm, arm_open, unlock, shutdown, relock
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (bus_wr && wr_enable) begin
                    state_d = open_d ? ST_UNLOCKED : ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (open_d) begin
                    state_d = ST_UNLOCKED;
                end
            end
            ST_UNLOCKED: begin
                if (bus_wr && !wr_enable) begin
                    state_d = ST_OFF;
                end else if (!open_d) begin
                    state_d = ST_ARMED;
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            if (bus_wr) begin
                sel_q <= bus_wdata[SEL_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sys_rst_req <= 1'b0;
        end else begin
            sys_rst_req <= expire;
        end
    end

    assign bus_rdata = {3'b000, open_q, run, sel_q};

endmodule

// File: rtl/wdog_guard_chk.sv
module wdog_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       kick,
    input logic       bus_wr,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       sys_rst_req
);
    logic [2:0] since_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= 3'd7;
        end else if (bus_wr && bus_wdata[4]) begin
            since_q <= 3'd0;
        end else if (since_q != 3'd7) begin
            since_q <= since_q + 3'd1;
        end
    end

    p_rsv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[7:5] == 3'b000);

    p_set_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_wdata[3]) |=> bus_rdata[3]);

    p_unlock_lapse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[4] |-> (since_q < 3'd4));

    p_clear_needs_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_rdata[3]) |-> $past(bus_rdata[4]));

    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |=> !sys_rst_req);

    p_kick_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !sys_rst_req);

    p_quiet_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |-> $past(bus_rdata[3]));

endmodule

bind wdog_guard wdog_guard_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .kick        (kick),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .sys_rst_req (sys_rst_req)
);

// File: tb/sim_wdog_guard.sv
module sim_wdog_guard;
    localparam int CLK_PERIOD = 10;
    localparam int BASE       = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       kick = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       sys_rst_req;

    int vectors = 0;
    int fails   = 0;
    int cyc     = 0;
    int exp_q[$];
    int got_exp;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdog_guard #(.BASE_SHIFT(BASE)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_en     (tick_en),
        .kick        (kick),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .sys_rst_req (sys_rst_req)
    );

    // monitor: every reset pulse must match the next expected cycle (R7)
    always @(negedge clk) begin
        if (rst_n && sys_rst_req) begin
            vectors++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R7: pulse at cycle %0d, expected none", cyc);
            end else begin
                got_exp = exp_q.pop_front();
                if (got_exp != cyc) begin
                    fails++;
                    $display("FAIL R7: pulse at cycle %0d, expected %0d", cyc, got_exp);
                end
            end
        end
    end

    task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string req);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        bus_wr    = 1'b1;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    // n ticks; expected pulses after tick lead, lead+per, ... (lead 0: none)
    task automatic run_ticks(input int n, input int lead, input int per);
        int c0 = cyc;
        if (lead > 0) begin
            for (int t = lead; t <= n; t += per) exp_q.push_back(c0 + t);
        end
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic do_kick(input logic with_tick);
        kick    = 1'b1;
        tick_en = with_tick;
        @(negedge clk);
        kick    = 1'b0;
        tick_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        chk(bus_rdata, 8'h00, "R1");
        chk({7'd0, sys_rst_req}, 8'h00, "R1");

        // enable with all bits set; reserved bits read back zero
        wr(8'hFF);
        chk(bus_rdata, 8'h1F, "R2/R3");
        idle(3);
        chk(bus_rdata, 8'h1F, "R4 still open");
        idle(1);
        chk(bus_rdata, 8'h0F, "R4 lapsed");

        // refused clear outside window, period still loaded
        wr(8'h02);
        chk(bus_rdata, 8'h0A, "R5");

        // period 16: back-to-back timeouts
        run_ticks(40, 16, 16);
        do_kick(1'b0);
        run_ticks(10, 0, 1);
        idle(20);                        // R11: no ticks, no progress
        run_ticks(5, 0, 1);
        run_ticks(1, 1, 1);              // R8/R11 16th tick after kick

        // kick and tick together: kick wins
        run_ticks(7, 0, 1);
        do_kick(1'b1);
        run_ticks(15, 0, 1);
        run_ticks(1, 1, 1);              // R8

        // period change clears, same value does not
        run_ticks(10, 0, 1);
        wr(8'h09);
        chk(bus_rdata, 8'h09, "R10");
        run_ticks(3, 0, 1);
        wr(8'h09);
        run_ticks(4, 0, 1);
        run_ticks(1, 1, 1);              // R10 eighth tick

        // shutdown four cycles after unlock
        run_ticks(5, 0, 1);
        wr(8'h19);
        chk(bus_rdata, 8'h19, "R6 unlocked");
        idle(3);
        wr(8'h01);
        chk(bus_rdata, 8'h01, "R6 last window cycle");
        run_ticks(40, 0, 1);             // R9 no pulses while off
        chk(bus_rdata, 8'h01, "R9");

        // re-enable needs a full period
        wr(8'h09);
        chk(bus_rdata, 8'h09, "R3");
        run_ticks(7, 0, 1);
        run_ticks(1, 1, 1);              // R9

        // shutdown five cycles after unlock: refused
        wr(8'h19);
        idle(4);
        wr(8'h01);
        chk(bus_rdata, 8'h09, "R6 late write");

        // shutdown one cycle after unlock
        wr(8'h19);
        wr(8'h03);
        chk(bus_rdata, 8'h13, "R6 first window cycle");
        idle(4);
        chk(bus_rdata, 8'h03, "R4");

        wr(8'hE0);
        chk(bus_rdata, 8'h00, "R2");

        idle(5);
        vectors++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R7: %0d pulses missing, expected 0", exp_q.size());
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule